// File: doc/BRIEF.md
# Serial EEPROM Boot Record Loader

This block runs once after reset. It checks a boot strap input and, if boot is allowed, reads a serial EEPROM over a mode-0 SPI link that it drives itself. It first reads four bytes from address zero using a two-byte address and compares them with a four-byte signature. From that result it works out whether the EEPROM takes two or three address bytes, or gives up. It then reads the boot stream that begins at EEPROM address 4 in a single continuous read.

The stream is a chain of records. Each record holds a type byte, a 16-bit byte count, a 16-bit target word address and then the payload. Each count and address is sent low byte first. Payload bytes are packed into words least-significant byte first. Instruction memory words are 32 bits wide and the two data memories use 16-bit words. Each finished word is written through one of three memory write ports. A record of an unknown type is read past and discarded. The execute record ends the boot: the block releases the EEPROM and gives a one-cycle strobe with the start address. If boot is not possible, the block raises a sticky skip flag and leaves the SPI bus idle.

Top module: `spi_boot_loader`

## Requirements
- R1: If `boot_strap_i` is low in the first cycle after reset, `skip_o` goes high, stays high, and chip select never falls.
- R2: The probe sends read command 0x03 and two zero address bytes, then reads four bytes. If those four bytes equal `SIGNATURE` (most significant byte first), two-byte addressing is used and the stream read sends 0x03, 0x00, 0x04.
- R3: If only probe bytes 1..3 equal the top three signature bytes, three-byte addressing is used and the stream read sends 0x03, 0x00, 0x00, 0x04.
- R4: If neither signature check holds, `skip_o` goes high after the single probe transaction, and no memory write or execute strobe occurs.
- R5: A type 0 record writes instruction memory. Bytes are packed four per word, least-significant first. The first word goes to the record address and later words go to the following word addresses.
- R6: A type 1 record writes X memory and a type 2 record writes Y memory. Bytes are packed two per 16-bit word, least-significant first, with incrementing word addresses.
- R7: If a record's byte count is not a multiple of the word size, the last partial word is still written, with its missing upper bytes set to zero.
- R8: A type 3 record gives `exec_o` for exactly one cycle with `exec_addr_o` equal to its address field. Chip select rises in the same cycle, `exec_addr_o` holds afterwards, and no later record is written.
- R9: A record with a type of 4 or above causes no write, and the record after it is parsed normally.
- R10: A record with a byte count of zero causes no write.
- R11: At most one of the three write enables and `exec_o` is high in any cycle, and `skip_o` and `exec_o` are never both high.
- R12: SPI is mode 0. `spi_sck_o` is low whenever chip select is high, including during reset. MOSI is sent MSB first and MISO is sampled while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_strap_i | input | 1 | Boot enable strap, sampled once after reset |
| spi_cs_no | output | 1 | EEPROM chip select, active low |
| spi_sck_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | Serial data to EEPROM |
| spi_miso_i | input | 1 | Serial data from EEPROM |
| imem_we_o | output | 1 | Instruction memory write strobe |
| imem_addr_o | output | 16 | Instruction memory word address |
| imem_wdata_o | output | 8*IWORD_BYTES | Instruction memory write word |
| xmem_we_o | output | 1 | X memory write strobe |
| xmem_addr_o | output | 16 | X memory word address |
| xmem_wdata_o | output | 8*DWORD_BYTES | X memory write word |
| ymem_we_o | output | 1 | Y memory write strobe |
| ymem_addr_o | output | 16 | Y memory word address |
| ymem_wdata_o | output | 8*DWORD_BYTES | Y memory write word |
| exec_o | output | 1 | One-cycle execute strobe |
| exec_addr_o | output | 16 | Start address from the execute record |
| skip_o | output | 1 | Sticky flag: boot was not attempted or failed |

## Verification
In the word packer, a byte can both fill a word and be the last byte of its record, so the full-word path and the end-of-record path fire in the same cycle. They must produce one write, not two. A four-byte record sent to a two-byte-word memory provokes this, and the bench then expects exactly two writes at consecutive addresses and the exact total write count. The other coincidence is the final write of a record against the execute strobe or the next record's start. This is judged by counting every cycle in which more than one strobe is high, which must stay at zero.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int unsigned REC_AW = 16;
  localparam logic [7:0] CMD_READ    = 8'h03;
  localparam logic [7:0] STREAM_BASE = 8'h04;
  localparam logic [7:0] REC_EXEC    = 8'd3;

  typedef enum logic [1:0] {
    TGT_I    = 2'd0,
    TGT_X    = 2'd1,
    TGT_Y    = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [3:0] {
    ST_STRAP,
    ST_PRB_CMD,
    ST_PRB_RD,
    ST_EVAL,
    ST_STR_CMD,
    ST_HDR,
    ST_DATA,
    ST_DONE,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/sbl_spi_byte.sv
module sbl_spi_byte #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          busy_q, ph_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic [CW-1:0] div_q;
  logic          tick;

  assign tick = (div_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      div_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sh_q   <= tx_i;
          bit_q  <= 3'd7;
          ph_q   <= 1'b0;
          div_q  <= '0;
        end
      end else if (tick) begin
        div_q <= '0;
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          // sample while sck is high, shift out next bit on the falling edge
          ph_q <= 1'b0;
          sh_q <= {sh_q[6:0], miso_i};
          if (bit_q == 3'd0) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q <= bit_q - 3'd1;
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

  assign sck_o  = busy_q & ph_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = sh_q;
endmodule

// File: rtl/sbl_packer.sv
module sbl_packer #(
  parameter int unsigned WB = 2,
  parameter int unsigned AW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [AW-1:0]   base_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  input  logic            last_i,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [8*WB-1:0] wdata_o
);
  localparam int unsigned DW = 8 * WB;
  localparam int unsigned LW = (WB > 1) ? $clog2(WB) : 1;

  logic [LW-1:0] lane_q;
  logic [DW-1:0] acc_q, merged;
  logic [AW-1:0] ptr_q;
  logic          full;

  always_comb begin
    merged = acc_q | (DW'(byte_i) << {lane_q, 3'b000});
    full   = (lane_q == LW'(WB - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= '0;
      acc_q   <= '0;
      ptr_q   <= '0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (load_i) begin
        ptr_q  <= base_i;
        lane_q <= '0;
        acc_q  <= '0;
      end else if (byte_valid_i) begin
        if (full || last_i) begin
          we_o    <= 1'b1;
          wdata_o <= merged;
          addr_o  <= ptr_q;
          ptr_q   <= ptr_q + AW'(1);
          lane_q  <= '0;
          acc_q   <= '0;
        end else begin
          acc_q  <= merged;
          lane_q <= lane_q + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import sbl_pkg::*;
#(
  parameter int unsigned SCK_HALF    = 2,
  parameter logic [31:0] SIGNATURE   = 32'h564C5349,
  parameter int unsigned IWORD_BYTES = 4,
  parameter int unsigned DWORD_BYTES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     boot_strap_i,
  output logic                     spi_cs_no,
  output logic                     spi_sck_o,
  output logic                     spi_mosi_o,
  input  logic                     spi_miso_i,
  output logic                     imem_we_o,
  output logic [15:0]              imem_addr_o,
  output logic [8*IWORD_BYTES-1:0] imem_wdata_o,
  output logic                     xmem_we_o,
  output logic [15:0]              xmem_addr_o,
  output logic [8*DWORD_BYTES-1:0] xmem_wdata_o,
  output logic                     ymem_we_o,
  output logic [15:0]              ymem_addr_o,
  output logic [8*DWORD_BYTES-1:0] ymem_wdata_o,
  output logic                     exec_o,
  output logic [15:0]              exec_addr_o,
  output logic                     skip_o
);
  localparam int unsigned AW = REC_AW;

  st_e           st_q;
  tgt_e          tgt_q;
  logic [2:0]    idx_q, last_cmd_idx;
  logic [15:0]   rem_q, len_q;
  logic [7:0]    type_q, alo_q, tx_q, tx_sel, spi_rx;
  logic [31:0]   sig_q;
  logic          mode24_q, start_q, infl_q, exec_q, skip_q;
  logic [AW-1:0] exec_addr_q, rec_addr;
  logic          byte_done, need_byte, hdr_end, data_v, data_last;

  sbl_spi_byte #(.HALF(SCK_HALF)) u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_q),
    .tx_i   (tx_q),
    .done_o (byte_done),
    .rx_o   (spi_rx),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .miso_i (spi_miso_i)
  );

  assign need_byte    = (st_q == ST_PRB_CMD) || (st_q == ST_PRB_RD) ||
                        (st_q == ST_STR_CMD) || (st_q == ST_HDR) || (st_q == ST_DATA);
  assign spi_cs_no    = !need_byte;
  assign last_cmd_idx = mode24_q ? 3'd3 : 3'd2;
  assign rec_addr     = {spi_rx, alo_q};
  assign hdr_end      = byte_done && (st_q == ST_HDR) && (idx_q == 3'd4);
  assign data_v       = byte_done && (st_q == ST_DATA);
  assign data_last    = (rem_q == 16'd1);

  always_comb begin
    tx_sel = 8'h00;
    if (idx_q == 3'd0 && (st_q == ST_PRB_CMD || st_q == ST_STR_CMD)) tx_sel = CMD_READ;
    else if (st_q == ST_STR_CMD && idx_q == last_cmd_idx)          tx_sel = STREAM_BASE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_STRAP;
      tgt_q       <= TGT_NONE;
      idx_q       <= '0;
      rem_q       <= '0;
      len_q       <= '0;
      type_q      <= '0;
      alo_q       <= '0;
      tx_q        <= '0;
      sig_q       <= '0;
      mode24_q    <= 1'b0;
      start_q     <= 1'b0;
      infl_q      <= 1'b0;
      exec_q      <= 1'b0;
      exec_addr_q <= '0;
      skip_q      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      exec_q  <= 1'b0;
      if (need_byte && !infl_q) begin
        start_q <= 1'b1;
        infl_q  <= 1'b1;
        tx_q    <= tx_sel;
      end
      if (byte_done) infl_q <= 1'b0;

      unique case (st_q)
        ST_STRAP: begin
          if (boot_strap_i) st_q <= ST_PRB_CMD;
          else begin
            skip_q <= 1'b1;
            st_q   <= ST_SKIP;
          end
        end
        ST_PRB_CMD: if (byte_done) begin
          if (idx_q == 3'd2) begin
            idx_q <= '0;
            st_q  <= ST_PRB_RD;
          end else idx_q <= idx_q + 3'd1;
        end
        ST_PRB_RD: if (byte_done) begin
          sig_q <= {sig_q[23:0], spi_rx};
          if (idx_q == 3'd3) begin
            idx_q <= '0;
            st_q  <= ST_EVAL;
          end else idx_q <= idx_q + 3'd1;
        end
        ST_EVAL: begin
          // a 3-byte-address part swallows the first read byte as an address byte
          if (sig_q == SIGNATURE) begin
            mode24_q <= 1'b0;
            st_q     <= ST_STR_CMD;
          end else if (sig_q[23:0] == SIGNATURE[31:8]) begin
            mode24_q <= 1'b1;
            st_q     <= ST_STR_CMD;
          end else begin
            skip_q <= 1'b1;
            st_q   <= ST_SKIP;
          end
        end
        ST_STR_CMD: if (byte_done) begin
          if (idx_q == last_cmd_idx) begin
            idx_q <= '0;
            st_q  <= ST_HDR;
          end else idx_q <= idx_q + 3'd1;
        end
        ST_HDR: if (byte_done) begin
          idx_q <= idx_q + 3'd1;
          unique case (idx_q)
            3'd0: type_q      <= spi_rx;
            3'd1: len_q[7:0]  <= spi_rx;
            3'd2: len_q[15:8] <= spi_rx;
            3'd3: alo_q       <= spi_rx;
            default: begin
              idx_q <= '0;
              if (type_q == REC_EXEC) begin
                exec_q      <= 1'b1;
                exec_addr_q <= rec_addr;
                st_q        <= ST_DONE;
              end else if (len_q != 16'd0) begin
                rem_q <= len_q;
                tgt_q <= (type_q < REC_EXEC) ? tgt_e'(type_q[1:0]) : TGT_NONE;
                st_q  <= ST_DATA;
              end
            end
          endcase
        end
        ST_DATA: if (byte_done) begin
          rem_q <= rem_q - 16'd1;
          if (data_last) st_q <= ST_HDR;
        end
        default: ;
      endcase
    end
  end

  sbl_packer #(.WB(IWORD_BYTES), .AW(AW)) u_pk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (hdr_end && type_q == 8'd0),
    .base_i      (rec_addr),
    .byte_valid_i(data_v && tgt_q == TGT_I),
    .byte_i      (spi_rx),
    .last_i      (data_last),
    .we_o        (imem_we_o),
    .addr_o      (imem_addr_o),
    .wdata_o     (imem_wdata_o)
  );

  sbl_packer #(.WB(DWORD_BYTES), .AW(AW)) u_pk_x (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (hdr_end && type_q == 8'd1),
    .base_i      (rec_addr),
    .byte_valid_i(data_v && tgt_q == TGT_X),
    .byte_i      (spi_rx),
    .last_i      (data_last),
    .we_o        (xmem_we_o),
    .addr_o      (xmem_addr_o),
    .wdata_o     (xmem_wdata_o)
  );

  sbl_packer #(.WB(DWORD_BYTES), .AW(AW)) u_pk_y (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (hdr_end && type_q == 8'd2),
    .base_i      (rec_addr),
    .byte_valid_i(data_v && tgt_q == TGT_Y),
    .byte_i      (spi_rx),
    .last_i      (data_last),
    .we_o        (ymem_we_o),
    .addr_o      (ymem_addr_o),
    .wdata_o     (ymem_wdata_o)
  );

  assign exec_o      = exec_q;
  assign exec_addr_o = exec_addr_q;
  assign skip_o      = skip_q;
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        spi_cs_no,
  input logic        spi_sck_o,
  input logic        imem_we_o,
  input logic        xmem_we_o,
  input logic        ymem_we_o,
  input logic        exec_o,
  input logic [15:0] exec_addr_o,
  input logic        skip_o
);
  a_r11_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({imem_we_o, xmem_we_o, ymem_we_o, exec_o}));

  a_r11_skip_vs_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> !exec_o);

  a_r1_skip_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> skip_o);

  a_r1_skip_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> spi_cs_no);

  a_r12_sck_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);

  a_r8_exec_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);

  a_r8_exec_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> spi_cs_no);

  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> $stable(exec_addr_o));

  a_r8_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !(imem_we_o || xmem_we_o || ymem_we_o));
endmodule

bind spi_boot_loader sbl_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .spi_cs_no  (spi_cs_no),
  .spi_sck_o  (spi_sck_o),
  .imem_we_o  (imem_we_o),
  .xmem_we_o  (xmem_we_o),
  .ymem_we_o  (ymem_we_o),
  .exec_o     (exec_o),
  .exec_addr_o(exec_addr_o),
  .skip_o     (skip_o)
);

// File: tb/sim_spi_boot_loader.sv
module sim_spi_boot_loader;
  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, miso = 1'b1;
  logic cs_n, sck, mosi, iwe, xwe, ywe, exec, skip;
  logic [15:0] iaddr, xaddr, yaddr, eaddr;
  logic [31:0] idata;
  logic [15:0] xdata, ydata;

  always #10 clk = ~clk;

  spi_boot_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .boot_strap_i(strap),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .imem_we_o(iwe), .imem_addr_o(iaddr), .imem_wdata_o(idata),
    .xmem_we_o(xwe), .xmem_addr_o(xaddr), .xmem_wdata_o(xdata),
    .ymem_we_o(ywe), .ymem_addr_o(yaddr), .ymem_wdata_o(ydata),
    .exec_o(exec), .exec_addr_o(eaddr), .skip_o(skip)
  );

  // behavioural EEPROM
  logic [7:0]  rom [256];
  int          nab = 2, bitc = 0, cs_falls = 0, dbit = 0;
  logic [7:0]  cmd_sh = '0;
  logic [23:0] adr_sh = '0;
  logic        prev_cs = 1'b1, prev_sck = 1'b0;

  always @(cs_n or sck) begin
    if (prev_cs && !cs_n) begin
      bitc = 0; cmd_sh = '0; adr_sh = '0; miso = 1'b1; cs_falls++;
    end else if (!cs_n && !prev_sck && sck) begin
      if (bitc < 8) cmd_sh = {cmd_sh[6:0], mosi};
      else if (bitc < 8 + 8*nab) adr_sh = {adr_sh[22:0], mosi};
      bitc++;
    end else if (!cs_n && prev_sck && !sck) begin
      if (bitc >= 8 + 8*nab) begin
        dbit = bitc - 8 - 8*nab;
        miso = rom[(int'(adr_sh) + dbit/8) & 255][7 - (dbit % 8)];
      end
    end
    prev_cs = cs_n; prev_sck = sck;
  end

  // strobe monitor
  int nlog = 0, n_exec = 0, n_multi = 0;
  logic [1:0]  lg_mem  [64];
  logic [15:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [15:0] ex_addr = '0;

  always @(negedge clk) if (rst_n) begin
    if ($countones({iwe, xwe, ywe, exec}) > 1) n_multi++;
    if (nlog < 64) begin
      if (iwe) begin lg_mem[nlog] = 2'd0; lg_addr[nlog] = iaddr; lg_data[nlog] = idata; nlog++; end
      else if (xwe) begin lg_mem[nlog] = 2'd1; lg_addr[nlog] = xaddr; lg_data[nlog] = {16'h0, xdata}; nlog++; end
      else if (ywe) begin lg_mem[nlog] = 2'd2; lg_addr[nlog] = yaddr; lg_data[nlog] = {16'h0, ydata}; nlog++; end
    end
    if (exec) begin n_exec++; ex_addr = eaddr; end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // boot stream from EEPROM address 4
  localparam int NIMG = 53;
  localparam logic [7:0] IMG [NIMG] = '{
    8'h00, 8'h06, 8'h00, 8'h10, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, // imem, 6 bytes
    8'h07, 8'h03, 8'h00, 8'h34, 8'h12, 8'hAA, 8'hBB, 8'hCC,                      // unknown type
    8'h01, 8'h04, 8'h00, 8'h00, 8'h02, 8'h01, 8'h02, 8'h03, 8'h04,               // xmem, 4 bytes
    8'h02, 8'h00, 8'h00, 8'h50, 8'h00,                                           // ymem, empty
    8'h02, 8'h03, 8'h00, 8'h00, 8'h03, 8'hA1, 8'hB2, 8'hC3,                      // ymem, 3 bytes
    8'h03, 8'h00, 8'h00, 8'h21, 8'h43,                                           // execute 0x4321
    8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 8'h99, 8'h99                              // must never load
  };

  typedef struct packed {
    logic [1:0]  mem;
    logic [15:0] addr;
    logic [31:0] data;
  } wr_t;

  localparam int NEXP = 6;
  localparam wr_t EXP [NEXP] = '{
    '{2'd0, 16'h0010, 32'h44332211},  // R5
    '{2'd0, 16'h0011, 32'h00006655},  // R7
    '{2'd1, 16'h0200, 32'h00000201},  // R6
    '{2'd1, 16'h0201, 32'h00000403},  // R6 word fill and record end coincide
    '{2'd2, 16'h0300, 32'h0000B2A1},  // R6
    '{2'd2, 16'h0301, 32'h000000C3}   // R7
  };

  task automatic build_image(bit good);
    for (int i = 0; i < 256; i++) rom[i] = 8'hFF;
    rom[0] = good ? 8'h56 : 8'h00;
    rom[1] = good ? 8'h4C : 8'h00;
    rom[2] = good ? 8'h53 : 8'h00;
    rom[3] = good ? 8'h49 : 8'h00;
    for (int i = 0; i < NIMG; i++) rom[4 + i] = IMG[i];
  endtask

  task automatic run_boot(bit s, int ab, bit good);
    build_image(good);
    nab = ab; strap = s; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nlog = 0; n_exec = 0; cs_falls = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (n_exec > 0 || skip) break;
    end
    if (n_exec == 0 && !skip) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: no exec or skip");
    end
    repeat (60) @(negedge clk);
  endtask

  task automatic check_loaded(string tag);
    chk({tag, " R2 read cmd"}, 32'(cmd_sh), 32'h03);
    chk({tag, " stream address"}, 32'(adr_sh), 32'h4);
    chk({tag, " R8 one exec"}, 32'(n_exec), 32'd1);
    chk({tag, " R8 exec addr held"}, 32'(eaddr), 32'h4321);
    chk({tag, " R8 exec strobe addr"}, 32'(ex_addr), 32'h4321);
    chk({tag, " R8 cs released"}, 32'(cs_n), 32'd1);
    chk({tag, " R8 R9 R10 write count"}, 32'(nlog), 32'(NEXP));
    for (int k = 0; k < NEXP; k++) begin
      chk({tag, " R5 R6 R7 mem"},  32'(lg_mem[k]),  32'(EXP[k].mem));
      chk({tag, " R5 R6 R7 addr"}, 32'(lg_addr[k]), 32'(EXP[k].addr));
      chk({tag, " R5 R6 R7 data"}, lg_data[k],      EXP[k].data);
    end
    for (int k = 0; k < nlog && k < 64; k++) begin
      chk({tag, " R9 unknown record not written"}, 32'(lg_addr[k] == 16'h1234), 32'd0);
      chk({tag, " R10 empty record not written"},  32'(lg_addr[k] == 16'h0050), 32'd0);
    end
    chk({tag, " R1 no skip"}, 32'(skip), 32'd0);
  endtask

  initial begin
    #(20ns * 190000);
    n_chk++; n_fail++;
    $display("FAIL global watchdog");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // reset state, R12
    strap = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 cs high in reset", 32'(cs_n), 32'd1);
    chk("R12 sck low in reset", 32'(sck), 32'd0);
    chk("R1 skip low in reset", 32'(skip), 32'd0);
    chk("R8 exec low in reset", 32'(exec), 32'd0);

    // two-byte-address part, R2
    run_boot(1'b1, 2, 1'b1);
    check_loaded("addr16");

    // three-byte-address part, R3
    run_boot(1'b1, 3, 1'b1);
    check_loaded("addr24 R3");

    // strap low, R1
    run_boot(1'b0, 2, 1'b1);
    chk("R1 skip set", 32'(skip), 32'd1);
    chk("R1 no chip select", 32'(cs_falls), 32'd0);
    chk("R1 no writes", 32'(nlog), 32'd0);

    // bad signature, R4
    run_boot(1'b1, 2, 1'b0);
    chk("R4 skip set", 32'(skip), 32'd1);
    chk("R4 single probe", 32'(cs_falls), 32'd1);
    chk("R4 no writes", 32'(nlog), 32'd0);
    chk("R4 no exec", 32'(n_exec), 32'd0);
    chk("R4 cs idle", 32'(cs_n), 32'd1);

    chk("R11 strobes exclusive", 32'(n_multi), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule